// File: doc/BRIEF.md
# Wired-AND Sequence Slot Synchronizer

This block steps a regulator power-up or power-down sequence through numbered slots. Several identical copies of it can share one open-drain line with an external pull-up. Each copy pulls the line low while it is busy in a slot. The line reads high only once every copy has let go. A copy moves to the next slot only when it sees the line high. In this way all copies stay in the same slot at the same time, and rails on different controllers can share a slot.

Before power-up, each copy holds the line low until its ON request arrives. During power-up, a slot ends when two things are true: the local slot timer has run out, and every rail mapped to that slot reports its undervoltage level reached. During power-down, a rail whose active discharge is enabled can stretch the slot until the rail reports it is discharged.

If a power-up slot overruns its timeout, the copy raises a fault. It then holds the line through a fixed timeout-sync wait and releases it. Once the line reads high, all copies start power-down together. When multi-device mode is off, the line is a plain output and the sequence ignores it.

Top module: `seq_slot_sync`

## Requirements
- R1: When `multi_i` is 0, `line_pd_o` equals the inverse of `gpo_i`, and slot advance does not wait on `line_i`. From `on_req_i` rising in the idle state, slot 0 starts 2 cycles later.
- R2: After reset, and while idle with `on_req_i` low, `line_pd_o` is 1. When `on_req_i` rises, `line_pd_o` drops to 0 one cycle later, but no slot starts until the line is seen released.
- R3: The line counts as released only after two consecutive high samples taken after a two-flop synchronizer. The state change it allows shows up 4 cycles after `line_i` goes high.
- R4: On entry to a slot, `line_pd_o` is 1. For that first cycle only, `slot_go_o` has exactly bit k set and `slot_o` equals k. Power-up visits slots 0 to N_SLOTS-1 in rising order.
- R5: In a power-up slot, `line_pd_o` falls TICK_DIV*dur+1 cycles after slot entry if every rail mapped to the slot has its undervoltage flag set. A flag that arrives late releases the line 1 cycle later.
- R6: A device that has released the line does not advance while any other device still holds the line low.
- R7: After the last power-up slot, the block holds the line released with no slot pulses. One cycle after `on_req_i` falls, power-down enters slot N_SLOTS-1 with `pwr_dn_o`=1. After slot 0 ends and the line is released, the block returns to idle and `line_pd_o` goes back to 1.
- R8: In a power-down slot, a rail with discharge enabled and its discharged flag clear keeps `line_pd_o` at 1 after the slot duration. Setting the flag releases the line 1 cycle later.
- R9: A power-down slot releases at TICK_DIV*dur+1 cycles in any of these cases: the bypass input is set, or no rail in the slot has discharge enabled. Without those, it releases at TICK_DIV*(dur+TMO_EXTRA)+1 cycles and raises no fault.
- R10: If a power-up slot overruns TICK_DIV*(dur+TMO_EXTRA)+1 cycles, `fault_o` rises and the line stays held for TICK_DIV*TSYNC_TICKS+1 more cycles. After that, once the line reads released, power-down starts at slot N_SLOTS-1. The fault stays set until the next power-up reaches slot 0.
- R11: `slot_go_o` never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| multi_i | input | 1 | 1 selects synchronized multi-device mode |
| gpo_i | input | 1 | Output level for the line when not in multi-device mode |
| on_req_i | input | 1 | Local ON request |
| bypass_i | input | 1 | Skip the discharged check in power-down slots |
| slot_dur_i | input | N_SLOTS*DUR_W | Duration of each slot in ticks; slot k sits at bits k*DUR_W |
| rail_slot_i | input | N_RAILS*SLOT_W | Slot index of each rail; rail r sits at bits r*SLOT_W |
| uv_ok_i | input | N_RAILS | Rail has reached its undervoltage level |
| dis_done_i | input | N_RAILS | Rail is below the short-to-ground level |
| dis_en_i | input | N_RAILS | Active discharge is enabled for the rail |
| line_i | input | 1 | Sampled level of the shared line |
| line_pd_o | output | 1 | Enable for the open-drain pull-down |
| slot_go_o | output | N_SLOTS | One-cycle pulse on entry to a slot |
| slot_o | output | SLOT_W | Current slot index |
| pwr_dn_o | output | 1 | A power-down slot is in progress |
| fault_o | output | 1 | A power-up slot has timed out |

## Verification
Each result has a fixed latency, and the bench checks it at that exact cycle:
- A line release shows up 4 cycles after the line rises.
- A timer-driven release comes TICK_DIV*dur+1 cycles after slot entry.
- A late rail flag releases the line 1 cycle later.
- An ON drop during the active state starts power-down 1 cycle later.

Inputs change on the falling clock edge. The bench then counts falling edges to the first one where the output has changed, and compares that count with the figure above. Holding cases are checked by sampling a cycle well past the due time, so a late or early change is caught.

// File: rtl/seqsync_pkg.sv
package seqsync_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WAIT_ALL,
        ST_UP_SLOT,
        ST_UP_REL,
        ST_ON,
        ST_DN_SLOT,
        ST_DN_REL,
        ST_TSYNC,
        ST_TS_REL
    } seq_state_e;

    typedef struct packed {
        logic up_ok;
        logic dn_ok;
    } rail_stat_t;

    // States in which the local device pulls the shared line low
    function automatic logic holds_line(seq_state_e s);
        return (s == ST_IDLE) || (s == ST_UP_SLOT) ||
               (s == ST_DN_SLOT) || (s == ST_TSYNC);
    endfunction

    function automatic logic is_slot(seq_state_e s);
        return (s == ST_UP_SLOT) || (s == ST_DN_SLOT);
    endfunction

endpackage

// File: rtl/seqsync_line_sampler.sv
module seqsync_line_sampler (
    input  logic clk_i,
    input  logic rst_i,
    input  logic line_i,
    output logic rel_o
);
    logic s1_q, s2_q, hi_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            hi_q <= 1'b0;
        end else begin
            s1_q <= line_i;
            s2_q <= s1_q;
            hi_q <= s2_q;
        end
    end

    assign rel_o = s2_q & hi_q;

    // R3: a release needs the line seen high through the synchronizer
    p_rel_needs_line_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        rel_o |-> $past(line_i, 2));

endmodule

// File: rtl/seqsync_slot_timer.sv
module seqsync_slot_timer #(
    parameter int TICK_DIV = 250,
    parameter int CNT_W    = 17,
    parameter int EXTRA    = 4
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             start_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             exp_o,
    output logic             tmo_o
);
    localparam int PW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;

    logic [PW-1:0]    presc_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   tmo_lim;

    always_ff @(posedge clk_i) begin
        if (rst_i || start_i) begin
            presc_q <= '0;
            cnt_q   <= '0;
        end else if (presc_q == PW'(TICK_DIV - 1)) begin
            presc_q <= '0;
            if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
        end else begin
            presc_q <= presc_q + 1'b1;
        end
    end

    assign tmo_lim = {1'b0, limit_i} + (CNT_W+1)'(EXTRA);
    assign exp_o   = cnt_q >= limit_i;
    assign tmo_o   = {1'b0, cnt_q} >= tmo_lim;

    // R5: the tick count only moves up until the next restart
    p_cnt_mono_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        !start_i |=> cnt_q >= $past(cnt_q));

endmodule

// File: rtl/seqsync_rail_check.sv
module seqsync_rail_check
    import seqsync_pkg::*;
#(
    parameter int N_RAILS = 8,
    parameter int SLOT_W  = 3
) (
    input  logic [SLOT_W-1:0]         slot_i,
    input  logic [N_RAILS*SLOT_W-1:0] rail_slot_i,
    input  logic [N_RAILS-1:0]        uv_i,
    input  logic [N_RAILS-1:0]        done_i,
    input  logic [N_RAILS-1:0]        den_i,
    output rail_stat_t                stat_o
);
    logic [N_RAILS-1:0] up_miss, dn_miss;

    for (genvar r = 0; r < N_RAILS; r++) begin : g_rail
        logic here;
        assign here       = rail_slot_i[r*SLOT_W +: SLOT_W] == slot_i;
        assign up_miss[r] = here & ~uv_i[r];
        assign dn_miss[r] = here & den_i[r] & ~done_i[r];
    end

    assign stat_o.up_ok = ~|up_miss;
    assign stat_o.dn_ok = ~|dn_miss;

endmodule

// File: rtl/seq_slot_sync.sv
module seq_slot_sync
    import seqsync_pkg::*;
#(
    parameter int N_SLOTS     = 6,
    parameter int N_RAILS     = 8,
    parameter int DUR_W       = 16,
    parameter int TICK_DIV    = 250,
    parameter int TMO_EXTRA   = 4,
    parameter int TSYNC_TICKS = 3000,
    parameter int SLOT_W      = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic                      clk_i,
    input  logic                      rst_i,
    input  logic                      multi_i,
    input  logic                      gpo_i,
    input  logic                      on_req_i,
    input  logic                      bypass_i,
    input  logic [N_SLOTS*DUR_W-1:0]  slot_dur_i,
    input  logic [N_RAILS*SLOT_W-1:0] rail_slot_i,
    input  logic [N_RAILS-1:0]        uv_ok_i,
    input  logic [N_RAILS-1:0]        dis_done_i,
    input  logic [N_RAILS-1:0]        dis_en_i,
    input  logic                      line_i,
    output logic                      line_pd_o,
    output logic [N_SLOTS-1:0]        slot_go_o,
    output logic [SLOT_W-1:0]         slot_o,
    output logic                      pwr_dn_o,
    output logic                      fault_o
);
    localparam int TS_W  = $clog2(TSYNC_TICKS + 1);
    localparam int CNT_W = ((DUR_W > TS_W) ? DUR_W : TS_W) + 1;
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(N_SLOTS - 1);

    seq_state_e         st_q, st_n;
    logic [SLOT_W-1:0]  slot_q, slot_n;
    logic [N_SLOTS-1:0] go_q;
    logic               fault_q;
    logic               line_rel, rel_eff;
    logic               tmr_start, tmr_exp, tmr_tmo;
    logic [DUR_W-1:0]   cur_dur;
    logic [CNT_W-1:0]   tmr_lim;
    rail_stat_t         rstat;

    seqsync_line_sampler u_samp (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .line_i(line_i),
        .rel_o (line_rel)
    );

    seqsync_rail_check #(.N_RAILS(N_RAILS), .SLOT_W(SLOT_W)) u_rails (
        .slot_i     (slot_q),
        .rail_slot_i(rail_slot_i),
        .uv_i       (uv_ok_i),
        .done_i     (dis_done_i),
        .den_i      (dis_en_i),
        .stat_o     (rstat)
    );

    always_comb begin
        cur_dur = '0;
        for (int k = 0; k < N_SLOTS; k++) begin
            if (slot_q == SLOT_W'(k)) cur_dur = slot_dur_i[k*DUR_W +: DUR_W];
        end
    end

    assign tmr_lim = (st_q == ST_TSYNC) ? CNT_W'(TSYNC_TICKS) : CNT_W'(cur_dur);

    seqsync_slot_timer #(.TICK_DIV(TICK_DIV), .CNT_W(CNT_W), .EXTRA(TMO_EXTRA)) u_tmr (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .start_i(tmr_start),
        .limit_i(tmr_lim),
        .exp_o  (tmr_exp),
        .tmo_o  (tmr_tmo)
    );

    assign rel_eff = ~multi_i | line_rel;

    always_comb begin
        st_n   = st_q;
        slot_n = slot_q;
        unique case (st_q)
            ST_IDLE:     if (on_req_i) st_n = ST_WAIT_ALL;
            ST_WAIT_ALL: begin
                if (!on_req_i) st_n = ST_IDLE;
                else if (rel_eff) begin
                    st_n   = ST_UP_SLOT;
                    slot_n = '0;
                end
            end
            ST_UP_SLOT: begin
                if (tmr_exp && rstat.up_ok) st_n = ST_UP_REL;
                else if (tmr_tmo)           st_n = ST_TSYNC;
            end
            ST_UP_REL: begin
                if (rel_eff) begin
                    if (slot_q == LAST) st_n = ST_ON;
                    else begin
                        st_n   = ST_UP_SLOT;
                        slot_n = slot_q + 1'b1;
                    end
                end
            end
            ST_ON: begin
                if (!on_req_i) begin
                    st_n   = ST_DN_SLOT;
                    slot_n = LAST;
                end
            end
            ST_DN_SLOT: begin
                if (tmr_exp && (bypass_i || rstat.dn_ok || tmr_tmo)) st_n = ST_DN_REL;
            end
            ST_DN_REL: begin
                if (rel_eff) begin
                    if (slot_q == '0) st_n = ST_IDLE;
                    else begin
                        st_n   = ST_DN_SLOT;
                        slot_n = slot_q - 1'b1;
                    end
                end
            end
            ST_TSYNC:  if (tmr_exp) st_n = ST_TS_REL;
            ST_TS_REL: begin
                if (rel_eff) begin
                    st_n   = ST_DN_SLOT;
                    slot_n = LAST;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    assign tmr_start = (st_n != st_q) &&
                       (is_slot(st_n) || (st_n == ST_TSYNC));

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q    <= ST_IDLE;
            slot_q  <= '0;
            go_q    <= '0;
            fault_q <= 1'b0;
        end else begin
            st_q   <= st_n;
            slot_q <= slot_n;
            for (int k = 0; k < N_SLOTS; k++) begin
                go_q[k] <= (st_n != st_q) && is_slot(st_n) && (slot_n == SLOT_W'(k));
            end
            if (st_q == ST_UP_SLOT && st_n == ST_TSYNC) fault_q <= 1'b1;
            else if (st_q == ST_WAIT_ALL && st_n == ST_UP_SLOT) fault_q <= 1'b0;
        end
    end

    assign line_pd_o = multi_i ? holds_line(st_q) : ~gpo_i;
    assign slot_go_o = go_q;
    assign slot_o    = slot_q;
    assign pwr_dn_o  = (st_q == ST_DN_SLOT) || (st_q == ST_DN_REL);
    assign fault_o   = fault_q;

    // R11: at most one slot pulse at a time
    p_go_onehot_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(slot_go_o));

    // R5: a power-up release only happens after the slot timer expired
    p_up_rel_exp_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q == ST_UP_REL) |-> tmr_exp);

    // R6: no advance while the shared line is still held by someone
    p_hold_wait_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (multi_i && (st_q == ST_UP_REL || st_q == ST_DN_REL) && !line_rel)
        |=> slot_go_o == '0);

    // R10: a fault only comes out of a power-up slot
    p_fault_src_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(fault_q) |-> $past(st_q) == ST_UP_SLOT);

    // R10: the timeout-sync hold lasts its full wait
    p_tsync_len_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q == ST_TS_REL && $past(st_q) == ST_TSYNC) |-> tmr_exp);

endmodule

// File: tb/seq_slot_sync_tb_top.sv
module seq_slot_sync_tb_top;

    localparam int NS = 3;
    localparam int NR = 3;
    localparam int DW = 6;
    localparam int TD = 4;
    localparam int TX = 3;
    localparam int TS = 5;
    localparam int SW = 2;

    logic          clk = 1'b0;
    logic          rst;
    logic          multi, gpo, on_req, bypass;
    logic [NS*DW-1:0] slot_dur;
    logic [NR*SW-1:0] rail_slot;
    logic [NR-1:0] uv, dis_done, dis_en;
    logic          peer_pd;
    wire           line;
    logic          line_pd;
    logic [NS-1:0] slot_go;
    logic [SW-1:0] slot_idx;
    logic          pwr_dn, fault;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    assign line = ~(line_pd | peer_pd);

    seq_slot_sync #(
        .N_SLOTS(NS), .N_RAILS(NR), .DUR_W(DW), .TICK_DIV(TD),
        .TMO_EXTRA(TX), .TSYNC_TICKS(TS)
    ) dut_i (
        .clk_i(clk), .rst_i(rst), .multi_i(multi), .gpo_i(gpo),
        .on_req_i(on_req), .bypass_i(bypass), .slot_dur_i(slot_dur),
        .rail_slot_i(rail_slot), .uv_ok_i(uv), .dis_done_i(dis_done),
        .dis_en_i(dis_en), .line_i(line), .line_pd_o(line_pd),
        .slot_go_o(slot_go), .slot_o(slot_idx), .pwr_dn_o(pwr_dn),
        .fault_o(fault)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // counts falling edges until a slot pulse shows up, then checks its bit and index
    task automatic wait_go(input int k, input int exp_c, input string tag);
        int c = 0;
        bit seen = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            c++;
            if (slot_go != '0) begin
                seen = 1;
                break;
            end
        end
        chk(seen && c == exp_c, tag, seen ? c : -1, exp_c);
        chk(slot_go == NS'(1 << k) && slot_idx == SW'(k), tag, int'(slot_go), 1 << k);
    endtask

    task automatic wait_pd(input logic val, input int exp_c, input string tag);
        int c = 0;
        bit seen = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            c++;
            if (line_pd == val) begin
                seen = 1;
                break;
            end
        end
        chk(seen && c == exp_c, tag, seen ? c : -1, exp_c);
    endtask

    task automatic do_reset(input logic m);
        rst = 1'b1; multi = m; gpo = 1'b1; on_req = 1'b0; bypass = 1'b0;
        uv = '0; dis_done = '0; dis_en = '0; peer_pd = 1'b0;
        step(3);
        rst = 1'b0;
        step(1);
    endtask

    // R2 reset state and idle hold
    task automatic t_reset;
        do_reset(1'b1);
        chk(line_pd == 1'b1, "R2 reset holds line", line_pd, 1);
        chk(slot_go == '0 && fault == 1'b0 && pwr_dn == 1'b0, "R2 reset outputs",
            int'(slot_go) + int'(fault) + int'(pwr_dn), 0);
        step(20);
        chk(line_pd == 1'b1, "R2 idle without ON", line_pd, 1);
    endtask

    // R2 R3 R4 R5 R6 R7 power-up in lockstep
    task automatic t_powerup;
        peer_pd = 1'b1;
        uv = 3'b101;
        on_req = 1'b1;
        wait_pd(1'b0, 1, "R2 ON releases line");
        step(15);
        chk(slot_go == '0 && line_pd == 1'b0, "R2 waits for peers", int'(slot_go), 0);
        peer_pd = 1'b0;
        wait_go(0, 4, "R3 start after line high");
        chk(line_pd == 1'b1, "R4 slot entry pulls line", line_pd, 1);
        peer_pd = 1'b1;
        step(1);
        chk(slot_go == '0, "R4 pulse lasts one cycle", int'(slot_go), 0);
        wait_pd(1'b0, TD * 2, "R5 slot0 release time");
        step(10);
        chk(slot_go == '0 && slot_idx == 2'd0, "R6 peer holds slot", int'(slot_idx), 0);
        peer_pd = 1'b0;
        wait_go(1, 4, "R6 advance on release");
        step(16);
        chk(line_pd == 1'b1, "R5 rail not ready holds", line_pd, 1);
        uv = 3'b111;
        wait_pd(1'b0, 1, "R5 late rail releases");
        wait_go(2, 4, "R4 slot order up");
        wait_pd(1'b0, TD * 1 + 1, "R5 slot2 release time");
        step(12);
        chk(line_pd == 1'b0 && slot_go == '0 && pwr_dn == 1'b0 && fault == 1'b0,
            "R7 active state", int'(line_pd), 0);
    endtask

    // R7 R8 R9 power-down
    task automatic t_powerdown;
        dis_en = 3'b011;
        dis_done = '0;
        on_req = 1'b0;
        wait_go(2, 1, "R7 down starts at last slot");
        chk(pwr_dn == 1'b1, "R7 down flag", pwr_dn, 1);
        wait_pd(1'b0, TD * 1 + 1, "R9 no discharge exact duration");
        wait_go(1, 4, "R7 down order");
        wait_pd(1'b0, TD * (3 + TX) + 1, "R9 discharge timeout");
        chk(fault == 1'b0, "R9 no fault on down timeout", fault, 0);
        wait_go(0, 4, "R7 down slot0");
        step(16);
        chk(line_pd == 1'b1, "R8 discharge extends slot", line_pd, 1);
        dis_done = 3'b001;
        wait_pd(1'b0, 1, "R8 discharged releases");
        step(5);
        chk(line_pd == 1'b1 && pwr_dn == 1'b0, "R7 back to idle", line_pd, 1);
    endtask

    // R10 power-up timeout and timeout-sync, R9 bypass
    task automatic t_timeout;
        uv = '0;
        dis_en = 3'b111;
        dis_done = '0;
        bypass = 1'b1;
        on_req = 1'b1;
        wait_go(0, 5, "R10 restart power-up");
        begin
            int c = 0;
            bit seen = 0;
            for (int i = 0; i < 200; i++) begin
                @(negedge clk);
                c++;
                if (fault) begin
                    seen = 1;
                    break;
                end
            end
            chk(seen && c == TD * (2 + TX) + 1, "R10 fault time", seen ? c : -1, TD * (2 + TX) + 1);
        end
        chk(line_pd == 1'b1, "R10 timeout-sync holds line", line_pd, 1);
        wait_pd(1'b0, TD * TS + 1, "R10 timeout-sync wait");
        wait_go(2, 4, "R10 joint power-down");
        chk(pwr_dn == 1'b1, "R10 down after timeout", pwr_dn, 1);
        wait_pd(1'b0, TD * 1 + 1, "R9 bypass ends extension");
        chk(fault == 1'b1, "R10 fault sticky", fault, 1);
    endtask

    // R1 single-device mode
    task automatic t_single;
        do_reset(1'b0);
        gpo = 1'b0;
        #1;
        chk(line_pd == 1'b1, "R1 gpo low drives line", line_pd, 1);
        gpo = 1'b1;
        #1;
        chk(line_pd == 1'b0, "R1 gpo high releases", line_pd, 0);
        peer_pd = 1'b1;
        uv = 3'b111;
        on_req = 1'b1;
        wait_go(0, 2, "R1 start ignores line");
        wait_go(1, TD * 2 + 2, "R1 advance ignores line");
        chk(line_pd == 1'b0, "R1 line follows gpo", line_pd, 0);
    endtask

    initial begin
        step(1);
        t_reset;
        t_powerup;
        t_powerdown;
        t_timeout;
        t_single;
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        slot_dur  = {6'd1, 6'd3, 6'd2};
        rail_slot = {2'd2, 2'd1, 2'd0};
    end

endmodule